// File: doc/BRIEF.md
# Synthesizer Power-Up Programming Sequencer

This block is the master side of a three-wire serial programming bus (serial clock, serial data, load strobe). On a start request it brings a fractional-N synthesizer up from cold. It first writes the PLL-enable register with its enable bit cleared, waits a programmable number of clock cycles, and then writes the same register again with its configured value. It then loads the remaining configuration registers in a fixed order, waits a second time, and writes the integer-divide register last. That last write starts the synthesizer's frequency calibration, so every other setting is already in place when calibration runs.

The register contents come in on a flat port that holds one 21-bit payload for each of the eight register addresses. The sequencer appends the 3-bit address to each payload to form a 24-bit frame, which it shifts out MSB first and latches with a load pulse. A parameter `HALF` sets the serial clock half-period in system clock cycles. The wait length is taken from the `wait_i` port, so a simulation can use short waits and silicon can use waits above 100 ms.

Top module: `pllseq_boot`

## Requirements
- R1: While reset is high and on the first cycle after it, `sclk_o`, `sdata_o`, `le_o`, `busy_o` and `done_o` are all 0.
- R2: A `start_i` pulse seen while idle sets `busy_o` to 1 and `done_o` to 0 from the next cycle.
- R3: Each frame is 24 bits sent MSB first. Bits 23:3 are the 21-bit payload taken from `cfg_i[a*21 +: 21]`, and bits 2:0 are the register address `a`.
- R4: The first frame goes to address 5, and its frame bit 6 (the PLL enable) is forced to 0. All other bits keep their configured values.
- R5: The second frame is the unmodified address-5 frame. It starts at least `wait_i` clock cycles after the first frame's load pulse ends.
- R6: Frames three to eight go to addresses 7, 6, 4, 3, 2, 1 in that order. Each one starts fewer than `wait_i` cycles after the previous load pulse ends.
- R7: The ninth and last frame goes to address 0. It starts at least `wait_i` cycles after the eighth frame's load pulse ends.
- R8: Every serial clock high phase lasts exactly `HALF` cycles, and `sdata_o` stays stable while `sclk_o` is high.
- R9: The load pulse rises only after all 24 bits are sent and at least `HALF` cycles after the last serial clock fall. It stays high exactly `HALF` cycles, and `sclk_o` is low throughout.
- R10: After the ninth load pulse, `busy_o` drops and `done_o` rises. `done_o` stays high until the next accepted start.
- R11: A `start_i` pulse while `busy_o` is high is ignored, and a run emits exactly nine frames.
- R12: A new start after `done_o` runs the full sequence again with the table and wait value present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| cfg_i | input | 168 | Eight 21-bit payloads, entry `a` at bits `a*21 +: 21` |
| wait_i | input | 24 | Wait length in clock cycles for the two long waits |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data, MSB first |
| le_o | output | 1 | Load strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete, held until the next start |

## Verification
`busy_o` is registered, so it is due one cycle after the `start_i` edge. The bench drives `start_i` on a falling edge and reads `busy_o` at the next falling edge. Serial results are timed by bus events rather than fixed offsets. A monitor samples the bus on every falling edge of the system clock and compares each frame to the scoreboard when its load pulse falls. It measures high-phase and load-pulse widths as run lengths that must equal `HALF`. It measures the gap from a load pulse to the next frame's first rising clock against `wait_i`, requiring at least `wait_i` cycles before the second and ninth frames and fewer than `wait_i` cycles elsewhere.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  localparam int NUM_STEPS = 9;
  localparam logic [3:0] LAST_STEP = 4'd8;

  typedef enum logic [2:0] {
    SR_IDLE, SR_LOW, SR_HIGH, SR_GAP, SR_LATCH
  } ser_state_t;

  typedef enum logic [1:0] {
    TS_IDLE, TS_SEND, TS_WAIT
  } top_state_t;

  // Register address written at each step of the bring-up
  function automatic logic [2:0] step_reg(input logic [3:0] idx);
    case (idx)
      4'd0, 4'd1: return 3'd5;
      4'd2:       return 3'd7;
      4'd3:       return 3'd6;
      4'd4:       return 3'd4;
      4'd5:       return 3'd3;
      4'd6:       return 3'd2;
      4'd7:       return 3'd1;
      default:    return 3'd0;
    endcase
  endfunction

  // Steps followed by a long wait
  function automatic logic step_waits(input logic [3:0] idx);
    return (idx == 4'd0) || (idx == 4'd7);
  endfunction

  // Step that holds the PLL disabled
  function automatic logic step_clears_en(input logic [3:0] idx);
    return idx == 4'd0;
  endfunction

endpackage

// File: rtl/pllseq_frame.sv
module pllseq_frame #(
  parameter int PAY_W   = 21,
  parameter int ADDR_W  = 3,
  parameter int PEN_BIT = 6,
  localparam int NREG    = 1 << ADDR_W,
  localparam int FRAME_W = PAY_W + ADDR_W
) (
  input  logic [NREG*PAY_W-1:0] cfg_i,
  input  logic [3:0]            step_i,
  output logic [FRAME_W-1:0]    frame_o
);
  import pllseq_pkg::*;

  logic [PAY_W-1:0]  tbl [NREG];
  logic [ADDR_W-1:0] addr;

  for (genvar g = 0; g < NREG; g++) begin : g_tbl
    assign tbl[g] = cfg_i[g*PAY_W +: PAY_W];
  end

  always_comb begin
    addr    = ADDR_W'(step_reg(step_i));
    frame_o = {tbl[addr], addr};
    if (step_clears_en(step_i)) frame_o[PEN_BIT] = 1'b0;
  end
endmodule

// File: rtl/pllseq_ser.sv
module pllseq_ser #(
  parameter int FRAME_W = 24,
  parameter int HALF    = 7,
  localparam int CW = $clog2(HALF + 1),
  localparam int BW = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sclk_o,
  output logic               sdata_o,
  output logic               le_o,
  output logic               fdone_o
);
  import pllseq_pkg::*;

  ser_state_t       st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bitn;
  logic [FRAME_W-1:0] sh;
  logic             last;

  assign last = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SR_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= '0;
      sclk_o  <= 1'b0;
      sdata_o <= 1'b0;
      le_o    <= 1'b0;
      fdone_o <= 1'b0;
    end else begin
      fdone_o <= 1'b0;
      case (st)
        SR_IDLE: if (go_i) begin
          sh      <= frame_i;
          sdata_o <= frame_i[FRAME_W-1];
          bitn    <= '0;
          cnt     <= '0;
          st      <= SR_LOW;
        end
        SR_LOW: if (last) begin
          cnt    <= '0;
          sclk_o <= 1'b1;
          st     <= SR_HIGH;
        end else cnt <= cnt + 1'b1;
        SR_HIGH: if (last) begin
          cnt    <= '0;
          sclk_o <= 1'b0;
          if (bitn == BW'(FRAME_W - 1)) begin
            sdata_o <= 1'b0;
            st      <= SR_GAP;
          end else begin
            sh      <= {sh[FRAME_W-2:0], 1'b0};
            sdata_o <= sh[FRAME_W-2];
            bitn    <= bitn + 1'b1;
            st      <= SR_LOW;
          end
        end else cnt <= cnt + 1'b1;
        SR_GAP: if (last) begin
          cnt  <= '0;
          le_o <= 1'b1;
          st   <= SR_LATCH;
        end else cnt <= cnt + 1'b1;
        SR_LATCH: if (last) begin
          cnt     <= '0;
          le_o    <= 1'b0;
          fdone_o <= 1'b1;
          st      <= SR_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= SR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pllseq_wait.sv
module pllseq_wait #(
  parameter int WAIT_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] len_i,
  output logic              fire_o
);
  logic [WAIT_W-1:0] cnt;
  logic              run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      run    <= 1'b0;
      fire_o <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (load_i) begin
        cnt <= len_i;
        run <= 1'b1;
      end else if (run) begin
        if (cnt == '0) begin
          run    <= 1'b0;
          fire_o <= 1'b1;
        end else cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pllseq_boot.sv
module pllseq_boot #(
  parameter int HALF    = 7,
  parameter int WAIT_W  = 24,
  parameter int PAY_W   = 21,
  parameter int ADDR_W  = 3,
  parameter int PEN_BIT = 6,
  localparam int NREG    = 1 << ADDR_W,
  localparam int FRAME_W = PAY_W + ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [NREG*PAY_W-1:0] cfg_i,
  input  logic [WAIT_W-1:0]     wait_i,
  output logic                  sclk_o,
  output logic                  sdata_o,
  output logic                  le_o,
  output logic                  busy_o,
  output logic                  done_o
);
  import pllseq_pkg::*;

  top_state_t         st;
  logic [3:0]         step;
  logic               go;
  logic               tload;
  logic               fdone;
  logic               fire;
  logic [FRAME_W-1:0] frame;

  pllseq_frame #(.PAY_W(PAY_W), .ADDR_W(ADDR_W), .PEN_BIT(PEN_BIT)) u_frame (
    .cfg_i(cfg_i), .step_i(step), .frame_o(frame)
  );

  pllseq_ser #(.FRAME_W(FRAME_W), .HALF(HALF)) u_ser (
    .clk(clk), .rst(rst), .go_i(go), .frame_i(frame),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .le_o(le_o), .fdone_o(fdone)
  );

  pllseq_wait #(.WAIT_W(WAIT_W)) u_wait (
    .clk(clk), .rst(rst), .load_i(tload), .len_i(wait_i), .fire_o(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TS_IDLE;
      step   <= '0;
      go     <= 1'b0;
      tload  <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      go    <= 1'b0;
      tload <= 1'b0;
      case (st)
        TS_IDLE: if (start_i) begin
          busy_o <= 1'b1;
          done_o <= 1'b0;
          step   <= '0;
          go     <= 1'b1;
          st     <= TS_SEND;
        end
        TS_SEND: if (fdone) begin
          if (step == LAST_STEP) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            st     <= TS_IDLE;
          end else if (step_waits(step)) begin
            tload <= 1'b1;
            st    <= TS_WAIT;
          end else begin
            step <= step + 1'b1;
            go   <= 1'b1;
          end
        end
        TS_WAIT: if (fire) begin
          step <= step + 1'b1;
          go   <= 1'b1;
          st   <= TS_SEND;
        end
        default: st <= TS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pllseq_boot_chk.sv
module pllseq_boot_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic sclk_o,
  input logic sdata_o,
  input logic le_o,
  input logic busy_o,
  input logic done_o
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_i && !busy_o |=> busy_o && !done_o); // R2
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    sclk_o && $past(sclk_o) |-> $stable(sdata_o)); // R8
  AST_LE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    le_o |-> !sclk_o); // R9
  AST_LE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(le_o) |=> le_o); // R9
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o)); // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> done_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !sclk_o && !le_o); // R11
endmodule

bind pllseq_boot pllseq_boot_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .sclk_o(sclk_o),
  .sdata_o(sdata_o), .le_o(le_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/pllseq_boot_bench.sv
module pllseq_boot_bench;
  localparam int HALF = 7;
  localparam int PW   = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [8*PW-1:0] cfg_i = '0;
  logic [23:0] wait_i = 24'd200;
  logic sclk_o, sdata_o, le_o, busy_o, done_o;

  int total = 0;
  int fails = 0;
  int wt = 200;
  logic [23:0] expq [$];

  always #2 clk = ~clk;

  pllseq_boot #(.HALF(HALF)) u_pllseq_boot (
    .clk(clk), .rst(rst), .start_i(start_i), .cfg_i(cfg_i), .wait_i(wait_i),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .le_o(le_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Driver: load a table and push the expected frame sequence
  task automatic push_seq(input int seed, input int wcyc);
    int order [9] = '{5, 5, 7, 6, 4, 3, 2, 1, 0};
    logic [PW-1:0] t [8];
    for (int a = 0; a < 8; a++) begin
      t[a] = PW'((32'h1A2B3 * (a + seed)) ^ 32'h5A5A);
      cfg_i[a*PW +: PW] = t[a];
    end
    t[5][3] = 1'b1;
    cfg_i[5*PW +: PW] = t[5];
    wait_i = 24'(wcyc);
    wt = wcyc;
    for (int s = 0; s < 9; s++) begin
      logic [23:0] f;
      f = {t[order[s]], 3'(order[s])};
      if (s == 0) f[6] = 1'b0;
      expq.push_back(f);
    end
  endtask

  // Monitor
  logic ps = 1'b0, pl = 1'b0, hold_d = 1'b0;
  int hi_run = 0, since_fall = 0, le_run = 0, gap = 0, nbits = 0, nframes = 0;
  bit tim_ok = 1'b1, le_ok = 1'b1;
  logic [23:0] shv = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sclk_o && !ps) begin
        if (nbits == 0 && (nframes % 9) != 0) begin
          if ((nframes % 9) == 1) chk(gap >= wt, "R5 wait before re-enable", gap, wt);
          else if ((nframes % 9) == 8) chk(gap >= wt, "R7 wait before last frame", gap, wt);
          else chk(gap < wt, "R6 no wait between frames", gap, wt);
        end
        shv = {shv[22:0], sdata_o};
        nbits++;
        hi_run = 1;
        hold_d = sdata_o;
      end else if (sclk_o) begin
        hi_run++;
        if (sdata_o != hold_d) tim_ok = 1'b0;
      end
      if (!sclk_o && ps) begin
        if (hi_run != HALF) tim_ok = 1'b0;
        since_fall = 1;
      end else if (!sclk_o) since_fall++;
      if (le_o && sclk_o) le_ok = 1'b0;
      if (le_o && !pl) begin
        if (nbits != 24 || since_fall < HALF) le_ok = 1'b0;
        le_run = 1;
      end else if (le_o) le_run++;
      if (!le_o && pl) begin
        logic [23:0] e;
        int idx;
        idx = nframes % 9;
        if (le_run != HALF) le_ok = 1'b0;
        e = (expq.size() > 0) ? expq.pop_front() : 24'hxxxxxx;
        if (idx == 0) chk(shv === e, "R4 (R3) first frame enable cleared", shv, e);
        else if (idx == 1) chk(shv === e, "R5 (R3) re-enable frame", shv, e);
        else if (idx == 8) chk(shv === e, "R7 (R3) final address-0 frame", shv, e);
        else chk(shv === e, "R6 (R3) ordered frame", shv, e);
        chk(tim_ok, "R8 clock high width and data stability", 32'(tim_ok), 1);
        chk(le_ok, "R9 load pulse placement and width", 32'(le_ok), 1);
        tim_ok = 1'b1;
        le_ok = 1'b1;
        nframes++;
        nbits = 0;
        gap = 0;
      end
      gap++;
      ps = sclk_o;
      pl = le_o;
    end
  end

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk({sclk_o, sdata_o, le_o, busy_o, done_o} == 5'b0, "R1 outputs in reset",
        {sclk_o, sdata_o, le_o, busy_o, done_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({sclk_o, sdata_o, le_o, busy_o, done_o} == 5'b0, "R1 outputs after reset",
        {sclk_o, sdata_o, le_o, busy_o, done_o}, 0);

    // Run 1
    push_seq(1, 200);
    pulse_start();
    chk(busy_o == 1'b1 && done_o == 1'b0, "R2 busy after start", {busy_o, done_o}, 2'b10);
    repeat (600) @(negedge clk);
    pulse_start();  // ignored while busy
    repeat (900) @(negedge clk);
    pulse_start();  // ignored while busy
    wait_done();
    chk(busy_o == 1'b0, "R10 busy dropped at done", busy_o, 0);
    chk(nframes == 9, "R11 nine frames per run", nframes, 9);
    chk(expq.size() == 0, "R11 scoreboard drained", expq.size(), 0);
    repeat (40) @(negedge clk);
    chk(done_o == 1'b1, "R10 done held", done_o, 1);
    chk(nframes == 9, "R11 no extra frame after done", nframes, 9);

    // Run 2: new table and wait length
    push_seq(7, 120);
    pulse_start();
    chk(busy_o == 1'b1 && done_o == 1'b0, "R12 restart clears done", {busy_o, done_o}, 2'b10);
    wait_done();
    chk(nframes == 18, "R12 second full sequence", nframes, 18);
    chk(expq.size() == 0, "R12 scoreboard drained", expq.size(), 0);
    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule